// File: doc/BRIEF.md
# Sixteen-bit Match-Frequency Timer

This block is a 16-bit up/down counter with a prescaler, reached through a small word-wide register bus. Software picks a divider, a waveform mode and a direction, loads a compare value and enables the counter. In match-frequency mode the compare value is the top of the count, so the period length is (compare + 1) prescaled ticks. In normal mode the counter uses the full 16-bit range. Each completed period raises an overflow flag, which can drive an interrupt line.

The direction, one-shot and interrupt-enable bits have no plain write port. Each has a set register and a clear register, written with a one in the matching bit. The overflow flag clears when a one is written to it. Any write to the control register keeps a status busy bit high for a short, fixed window. A soft reset requested through the control register completes at the end of that window.

Register offsets on `bus_addr`:

| Offset | Register |
|---|---|
| 0x0 | control |
| 0x1 | mode clear |
| 0x2 | mode set |
| 0x3 | interrupt-enable clear |
| 0x4 | interrupt-enable set |
| 0x5 | flag |
| 0x6 | status |
| 0x7 | count, read only |
| 0x8 | compare |

Reads are combinational from `bus_addr`. A write takes effect on the clock edge where `bus_we` is high.

Top module: `tmr16_match`

## Requirements
- R1: After `rst_n` is released, every register reads 0 and `irq_o` is 0.
- R2: Control bits 4:2 select the prescaler. Codes 0 to 7 give dividers 1, 2, 4, 8, 16, 64, 256 and 1024. While enabled, the count moves once at the end of every divider-th clock, counted from the edge that wrote the enable.
- R3: Control bits 6:5 select the mode, and 01 is match-frequency. In that mode an up count that has reached the compare value (offset 0x8) goes to 0 on the next tick and sets the flag (bit 0 at 0x5). In any other mode, up counting ignores the compare value and wraps only at 0xFFFF, and down counting reloads 0xFFFF.
- R4: With the direction bit set (mode bit 0), the counter counts down. On the tick after it reaches 0, it reloads the top value (the compare value in match-frequency mode) and sets the flag.
- R5: With the one-shot bit set (mode bit 1), the tick that ends a period sets the flag and clears enable (control bit 1), and the count stays where it is.
- R6: Writing 1 to flag bit 0 clears the flag. Writing 0 leaves it unchanged. A period end in the same cycle wins over the clear.
- R7: Writing a one to a bit of a set register (0x2, 0x4) sets that bit, and writing a one to a clear register (0x1, 0x3) clears it. Zero bits have no effect. Reading either register of a pair returns the current bits.
- R8: `irq_o` equals the flag AND the interrupt-enable bit (bit 0 at 0x3/0x4).
- R9: Status bit 0 (busy) reads 1 for exactly the two cycles after any control write, and 0 otherwise.
- R10: Writing a control value with bit 0 set requests a soft reset. The other bits of that write are ignored. Control bit 0 reads 1 while the request is busy, and then every register returns to its reset value.
- R11: While enable is 0, the count holds and the prescaler is cleared. After a new enable, the first tick arrives a full divider period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
Every cycle, the assertions check these rules: the wrap to 0 at the top, the reload when counting down from 0, a held count while disabled or after a one-shot stop, a cleared prescaler while idle, busy going high after a control write, and a soft reset clearing the registers. Only the bench's scenarios can show that the period length is right for each divider, that the prescaler restarts from zero after a re-enable, that normal mode ignores the compare value, and that a written 0 leaves the flag unchanged. The bench does this by sweeping all eight prescaler codes and checking the count against a value it computes arithmetically.

// File: rtl/tmr_pkg.sv
// Package: shared constants, register offsets and the prescaler decode
// for the 16-bit match-frequency timer.
// Assumes: register offsets fit in REG_AW bits.
package tmr_pkg;

    localparam int REG_AW   = 4;
    localparam int PSEL_W   = 3;
    localparam int WAVE_W   = 2;

    // Register offsets on the bus
    localparam logic [REG_AW-1:0] OFS_CTRL    = 4'h0;
    localparam logic [REG_AW-1:0] OFS_MODECLR = 4'h1;
    localparam logic [REG_AW-1:0] OFS_MODESET = 4'h2;
    localparam logic [REG_AW-1:0] OFS_IENCLR  = 4'h3;
    localparam logic [REG_AW-1:0] OFS_IENSET  = 4'h4;
    localparam logic [REG_AW-1:0] OFS_FLAG    = 4'h5;
    localparam logic [REG_AW-1:0] OFS_STAT    = 4'h6;
    localparam logic [REG_AW-1:0] OFS_CNT     = 4'h7;
    localparam logic [REG_AW-1:0] OFS_TOP     = 4'h8;

    // Waveform modes
    typedef enum logic [WAVE_W-1:0] {
        WAVE_NORMAL = 2'b00,
        WAVE_MATCH  = 2'b01,
        WAVE_RSV2   = 2'b10,
        WAVE_RSV3   = 2'b11
    } wave_e;

    // Returns log2 of the divider selected by a prescaler code
    function automatic logic [3:0] psc_shift(input logic [PSEL_W-1:0] code);
        logic [3:0] sh;
        case (code)
            3'd0: sh = 4'd0;
            3'd1: sh = 4'd1;
            3'd2: sh = 4'd2;
            3'd3: sh = 4'd3;
            3'd4: sh = 4'd4;
            3'd5: sh = 4'd6;
            3'd6: sh = 4'd8;
            default: sh = 4'd10;
        endcase
        return sh;
    endfunction

endpackage

// File: rtl/tmr_presc.sv
// Module: tmr_presc
// Free-running prescale counter. It produces a one-cycle tick at the end
// of every divider period while run is high.
// Assumes: PSC_W >= 10, so the largest divider (1024) fits. The counter
// is held at zero whenever run is low.
module tmr_presc
    import tmr_pkg::*;
#(
    parameter int PSC_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PSEL_W-1:0] sel,
    output logic              tick
);

    logic [PSC_W-1:0] pcnt;
    logic [PSC_W-1:0] mask;
    logic [3:0]       sh;

    // Decode the divider into a low-bit mask
    always_comb begin
        sh   = psc_shift(sel);
        mask = (PSC_W'(1) << sh) - PSC_W'(1);
        tick = run && ((pcnt & mask) == mask);
    end

    // Advance the prescale count, clear it when not running
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + PSC_W'(1);
        end
    end

    // R11
    psc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pcnt == '0));

endmodule

// File: rtl/tmr_count.sv
// Module: tmr_count
// The main up/down counter. It moves one step per prescaler tick and
// reports the end of a period. In match mode the period ends at top,
// otherwise at the full 16-bit range.
// Assumes: clr is a one-cycle soft-reset pulse and has priority over counting.
module tmr_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             tick,
    input  logic             dn,
    input  logic             oneshot,
    input  logic             match_mode,
    input  logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] count,
    output logic             ovf_evt,
    output logic             stop_evt
);

    logic [CNT_W-1:0] limit;
    logic             at_end;

    // Pick the period limit and detect the last step of a period
    always_comb begin
        limit    = match_mode ? top : {CNT_W{1'b1}};
        at_end   = dn ? (count == '0) : (count == limit);
        ovf_evt  = run && tick && at_end;
        stop_evt = ovf_evt && oneshot;
    end

    // Count, wrap or reload on each tick
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (run && tick) begin
            if (at_end) begin
                if (!oneshot) begin
                    count <= dn ? limit : '0;
                end
            end else begin
                count <= dn ? (count - CNT_W'(1)) : (count + CNT_W'(1));
            end
        end
    end

    // R3
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !dn && !oneshot && !clr) |=> (count == '0));

    // R4
    dn_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && dn && !oneshot && !clr) |=> (count == $past(limit)));

    // R5
    oneshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !clr) |=> $stable(count));

    // R11
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(count));

endmodule

// File: rtl/tmr_sync.sv
// Module: tmr_sync
// Models the write-synchronisation delay of the control register. Each
// control write holds busy for SYNC_CYC cycles. A soft-reset request
// stays pending until the last busy cycle and then fires for one cycle.
// Assumes: SYNC_CYC >= 1. A new control write restarts the window.
module tmr_sync #(
    parameter int SYNC_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctrl,
    input  logic srst_req,
    output logic busy,
    output logic srst_pend,
    output logic srst_fire
);

    localparam int SW = $clog2(SYNC_CYC + 1);

    logic [SW-1:0] wcnt;

    // Derive the busy level and the reset pulse
    always_comb begin
        busy      = (wcnt != '0);
        srst_fire = srst_pend && (wcnt == SW'(1));
    end

    // Load the window on a control write, then count it down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= '0;
        end else if (wr_ctrl) begin
            wcnt <= SW'(SYNC_CYC);
        end else if (wcnt != '0) begin
            wcnt <= wcnt - SW'(1);
        end
    end

    // Hold the soft-reset request until it fires
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srst_pend <= 1'b0;
        end else if (wr_ctrl && srst_req) begin
            srst_pend <= 1'b1;
        end else if (srst_fire) begin
            srst_pend <= 1'b0;
        end
    end

    // R9
    busy_on_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> busy);

    // R10
    srst_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_fire && !wr_ctrl) |=> !srst_pend);

endmodule

// File: rtl/tmr16_match.sv
// Module: tmr16_match
// Top level of the timer. Holds the register file, decodes the bus and
// connects the prescaler, the counter and the sync sequencer.
// Assumes: single-cycle writes, combinational reads, DATA_W >= CNT_W,
// and DATA_W >= 8.
module tmr16_match
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DATA_W   = 16,
    parameter int PSC_W    = 10,
    parameter int SYNC_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);

    localparam int CTRL_W = 1 + 1 + PSEL_W + WAVE_W + 1;

    logic              en_q;
    logic [PSEL_W-1:0] psc_q;
    wave_e             wave_q;
    logic              stby_q;
    logic              dn_q;
    logic              os_q;
    logic              ien_q;
    logic              flag_q;
    logic [CNT_W-1:0]  top_q;

    logic              wr_ctrl, wr_mclr, wr_mset, wr_iclr, wr_iset, wr_flag, wr_top;
    logic              busy, srst_pend, srst_fire;
    logic              tick, ovf_evt, stop_evt;
    logic [CNT_W-1:0]  count;
    logic [CTRL_W-1:0] ctrl_rd;

    // Decode the write strobes
    always_comb begin
        wr_ctrl = bus_we && (bus_addr == OFS_CTRL);
        wr_mclr = bus_we && (bus_addr == OFS_MODECLR);
        wr_mset = bus_we && (bus_addr == OFS_MODESET);
        wr_iclr = bus_we && (bus_addr == OFS_IENCLR);
        wr_iset = bus_we && (bus_addr == OFS_IENSET);
        wr_flag = bus_we && (bus_addr == OFS_FLAG);
        wr_top  = bus_we && (bus_addr == OFS_TOP);
    end

    tmr_sync #(.SYNC_CYC(SYNC_CYC)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .srst_req  (bus_wdata[0]),
        .busy      (busy),
        .srst_pend (srst_pend),
        .srst_fire (srst_fire)
    );

    tmr_presc #(.PSC_W(PSC_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (en_q),
        .sel   (psc_q),
        .tick  (tick)
    );

    tmr_count #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (srst_fire),
        .run        (en_q),
        .tick       (tick),
        .dn         (dn_q),
        .oneshot    (os_q),
        .match_mode (wave_q == WAVE_MATCH),
        .top        (top_q),
        .count      (count),
        .ovf_evt    (ovf_evt),
        .stop_evt   (stop_evt)
    );

    // Control register: a one-shot stop clears enable, and a write without
    // a reset request loads the fields
    always_ff @(posedge clk) begin
        if (!rst_n || srst_fire) begin
            en_q   <= 1'b0;
            psc_q  <= '0;
            wave_q <= WAVE_NORMAL;
            stby_q <= 1'b0;
        end else begin
            if (stop_evt) begin
                en_q <= 1'b0;
            end
            if (wr_ctrl && !bus_wdata[0]) begin
                en_q   <= bus_wdata[1];
                psc_q  <= bus_wdata[2 +: PSEL_W];
                wave_q <= wave_e'(bus_wdata[2+PSEL_W +: WAVE_W]);
                stby_q <= bus_wdata[2+PSEL_W+WAVE_W];
            end
        end
    end

    // Direction and one-shot bits through the set/clear pair
    always_ff @(posedge clk) begin
        if (!rst_n || srst_fire) begin
            dn_q <= 1'b0;
            os_q <= 1'b0;
        end else if (wr_mset) begin
            dn_q <= dn_q | bus_wdata[0];
            os_q <= os_q | bus_wdata[1];
        end else if (wr_mclr) begin
            dn_q <= dn_q & ~bus_wdata[0];
            os_q <= os_q & ~bus_wdata[1];
        end
    end

    // Interrupt-enable bit through the set/clear pair
    always_ff @(posedge clk) begin
        if (!rst_n || srst_fire) begin
            ien_q <= 1'b0;
        end else if (wr_iset) begin
            ien_q <= ien_q | bus_wdata[0];
        end else if (wr_iclr) begin
            ien_q <= ien_q & ~bus_wdata[0];
        end
    end

    // Overflow flag: set by period end, cleared by writing a one
    always_ff @(posedge clk) begin
        if (!rst_n || srst_fire) begin
            flag_q <= 1'b0;
        end else if (ovf_evt) begin
            flag_q <= 1'b1;
        end else if (wr_flag && bus_wdata[0]) begin
            flag_q <= 1'b0;
        end
    end

    // Compare / top register
    always_ff @(posedge clk) begin
        if (!rst_n || srst_fire) begin
            top_q <= '0;
        end else if (wr_top) begin
            top_q <= bus_wdata[CNT_W-1:0];
        end
    end

    // Read mux and interrupt output
    always_comb begin
        ctrl_rd = {stby_q, wave_q, psc_q, en_q, srst_pend};
        irq_o   = flag_q & ien_q;
        case (bus_addr)
            OFS_CTRL:    bus_rdata = DATA_W'(ctrl_rd);
            OFS_MODECLR,
            OFS_MODESET: bus_rdata = DATA_W'({os_q, dn_q});
            OFS_IENCLR,
            OFS_IENSET:  bus_rdata = DATA_W'(ien_q);
            OFS_FLAG:    bus_rdata = DATA_W'(flag_q);
            OFS_STAT:    bus_rdata = DATA_W'(busy);
            OFS_CNT:     bus_rdata = DATA_W'(count);
            OFS_TOP:     bus_rdata = DATA_W'(top_q);
            default:     bus_rdata = '0;
        endcase
    end

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !srst_fire) |=> flag_q);

    // R5
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !wr_ctrl && !srst_fire) |=> !en_q);

    // R10
    srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_fire |=> (top_q == '0 && !en_q && !flag_q && !ien_q));

endmodule

// File: tb/tmr16_match_bench.sv
`timescale 1ns/1ps
module tmr16_match_bench;

    localparam logic [3:0] A_CTRL = 4'h0, A_MCLR = 4'h1, A_MSET = 4'h2,
                           A_ICLR = 4'h3, A_ISET = 4'h4, A_FLAG = 4'h5,
                           A_STAT = 4'h6, A_CNT  = 4'h7, A_TOP  = 4'h8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tmr16_match u_tmr16_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic soft_rst;
        wr(A_CTRL, 16'h0001);
        step(2);
    endtask

    function automatic int divof(input int code);
        int t[8] = '{1, 2, 4, 8, 16, 64, 256, 1024};
        return t[code];
    endfunction

    initial begin
        logic [15:0] v;
        logic [15:0] c0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        rd(A_CTRL, v); chk("R1 ctrl", v, 0);
        rd(A_STAT, v); chk("R1 stat", v, 0);
        rd(A_CNT, v);  chk("R1 count", v, 0);
        rd(A_TOP, v);  chk("R1 top", v, 0);
        step(1);
        rd(A_FLAG, v); chk("R1 flag", v, 0);
        rd(A_MSET, v); chk("R1 mode", v, 0);
        chk("R1 irq", irq_o, 0);

        // R7 set/clear pairs
        wr(A_MSET, 16'h0003);
        rd(A_MCLR, v); chk("R7 set both", v, 3);
        wr(A_MCLR, 16'h0001);
        rd(A_MSET, v); chk("R7 clear dir", v, 2);
        wr(A_MSET, 16'h0000);
        rd(A_MSET, v); chk("R7 zero ignored", v, 2);
        wr(A_ISET, 16'h0001);
        rd(A_ICLR, v); chk("R7 ien set", v, 1);
        wr(A_ICLR, 16'h0001);
        rd(A_ISET, v); chk("R7 ien clear", v, 0);

        // R9 busy window and R10 soft reset
        wr(A_TOP, 16'h1234);
        wr(A_CTRL, 16'h0003);
        rd(A_STAT, v); chk("R9 busy k0", v, 1);
        rd(A_CTRL, v); chk("R10 pending k0", v & 16'h3, 16'h1);
        step(1);
        rd(A_STAT, v); chk("R9 busy k1", v, 1);
        rd(A_CTRL, v); chk("R10 pending k1", v & 16'h1, 16'h1);
        step(1);
        rd(A_STAT, v); chk("R9 idle k2", v, 0);
        rd(A_CTRL, v); chk("R10 ctrl cleared", v, 0);
        rd(A_TOP, v);  chk("R10 top cleared", v, 0);
        rd(A_MSET, v); chk("R10 mode cleared", v, 0);

        // R2 / R3 sweep over every prescaler code in match mode, top=3
        for (int c = 0; c < 8; c++) begin
            int d;
            d = divof(c);
            soft_rst();
            wr(A_TOP, 16'd3);
            wr(A_ISET, 16'h0001);
            wr(A_CTRL, 16'(32'h20 | (c << 2) | 2));
            for (int k = 1; k <= 8 * d; k++) begin
                step(1);
                rd(A_CNT, v);
                chk($sformatf("R2 R3 code%0d k%0d count", c, k), v, 16'((k / d) % 4));
                if (k == 4 * d - 1 || k == 4 * d) begin
                    rd(A_FLAG, v);
                    chk($sformatf("R3 code%0d k%0d flag", c, k), v, (k == 4 * d) ? 1 : 0);
                    chk($sformatf("R8 code%0d k%0d irq", c, k), irq_o, (k == 4 * d) ? 1 : 0);
                end
            end
        end

        // R6 / R8 flag handling (flag set, next period far away)
        wr(A_FLAG, 16'h0000);
        rd(A_FLAG, v); chk("R6 write 0 keeps flag", v, 1);
        chk("R8 irq high", irq_o, 1);
        wr(A_ICLR, 16'h0001);
        chk("R8 irq masked", irq_o, 0);
        rd(A_FLAG, v); chk("R8 flag kept", v, 1);
        wr(A_FLAG, 16'h0001);
        rd(A_FLAG, v); chk("R6 write 1 clears", v, 0);

        // R4 down count in match mode, top=2, divider 1
        soft_rst();
        wr(A_TOP, 16'd2);
        wr(A_MSET, 16'h0001);
        wr(A_CTRL, 16'h0022);
        for (int k = 1; k <= 7; k++) begin
            step(1);
            rd(A_CNT, v);
            chk($sformatf("R4 down k%0d", k), v, 16'((3 - (k % 3)) % 3));
        end
        rd(A_FLAG, v); chk("R4 flag", v, 1);

        // R3 normal mode down reloads full range
        soft_rst();
        wr(A_TOP, 16'd5);
        wr(A_MSET, 16'h0001);
        wr(A_CTRL, 16'h0002);
        step(1);
        rd(A_CNT, v); chk("R3 normal down reload", v, 16'hFFFF);
        step(1);
        rd(A_CNT, v); chk("R3 normal down step", v, 16'hFFFE);

        // R3 normal mode up ignores compare
        soft_rst();
        wr(A_TOP, 16'd3);
        wr(A_CTRL, 16'h0002);
        step(5);
        rd(A_CNT, v);  chk("R3 normal passes top", v, 5);
        rd(A_FLAG, v); chk("R3 normal no flag", v, 0);

        // R5 one-shot, top=2, divider 1
        soft_rst();
        wr(A_TOP, 16'd2);
        wr(A_MSET, 16'h0002);
        wr(A_CTRL, 16'h0022);
        for (int k = 1; k <= 3; k++) begin
            step(1);
            rd(A_CNT, v);
            chk($sformatf("R5 oneshot k%0d", k), v, 16'((k < 2) ? k : 2));
        end
        rd(A_FLAG, v); chk("R5 flag", v, 1);
        rd(A_CTRL, v); chk("R5 enable cleared", v & 16'h2, 0);
        step(4);
        rd(A_CNT, v);  chk("R5 count held", v, 2);

        // R11 freeze while disabled, prescaler restart on re-enable
        soft_rst();
        wr(A_TOP, 16'd100);
        wr(A_CTRL, 16'h0022);
        step(5);
        rd(A_CNT, v); chk("R11 running", v, 5);
        wr(A_CTRL, 16'h0020);
        rd(A_CNT, c0); chk("R11 last step at disable", c0, 7);
        step(3);
        rd(A_CNT, v); chk("R11 frozen", v, c0);
        wr(A_CTRL, 16'h002A);
        step(3);
        rd(A_CNT, v); chk("R11 no early tick", v, c0);
        step(1);
        rd(A_CNT, v); chk("R11 first tick after div4", v, c0 + 1);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule